// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator machine. Each operation takes an operation code, an accumulator operand, a memory operand and the current 8-bit status byte. It returns a result byte and the status byte that follows. The arithmetic is binary only. The block holds no registers of its own except an optional output stage. The surrounding datapath decides whether to write the result back into the accumulator or an index register, or to ignore it.

The supported operations are:
- add with carry in, and subtract with carry used as an inverted borrow;
- AND, OR and exclusive-OR;
- compare, which updates flags only;
- increment and decrement of the accumulator operand;
- shift and rotate by one bit in either direction;
- setting or clearing any single status bit chosen by a 3-bit index.

Status bits that an operation does not own pass through unchanged. The parameter `OUT_REG` chooses between a purely combinational path and one register stage on both outputs.

Top module: `alu8_core`

## Requirements
- R1: Status layout is carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, break bit 4, spare bit 5, overflow bit 6, negative bit 7; every opcode except 12 and 13 returns bits 5..2 equal to their input values.
- R2: Every opcode that produces a result (0-4, 6-11) sets zero exactly when the result is 0x00 and copies result bit 7 into negative.
- R3: Opcode 0 (add) returns A+M+C modulo 256 and sets carry when the 9-bit sum exceeds 0xFF.
- R4: Add sets overflow when A and M share a sign and the result sign differs. Subtract sets overflow when A and M differ in sign and the result sign differs from A.
- R5: Opcode 1 (subtract) returns A-M, less one more when carry is clear, and sets carry when no unsigned borrow occurred.
- R6: Opcode 5 (compare) sets carry when A >= M, and sets zero and negative from (A-M) modulo 256. It returns A unchanged as the result and leaves overflow unchanged.
- R7: Opcodes 6 (increment) and 7 (decrement) act on A modulo 256 and leave carry and overflow unchanged.
- R8: Opcodes 2 (AND), 3 (OR) and 4 (exclusive-OR) combine A with M bitwise and leave carry and overflow unchanged.
- R9: Opcode 8 (shift left) moves A bit 7 into carry and fills bit 0 with 0. Opcode 9 (shift right) moves A bit 0 into carry and fills bit 7 with 0. Overflow is unchanged.
- R10: Opcode 10 (rotate left) feeds the old carry into bit 0, and opcode 11 (rotate right) feeds it into bit 7. Both load carry from the bit shifted out.
- R11: Opcode 12 sets and opcode 13 clears the status bit indexed by the flag-select input. All other status bits are unchanged, and the result is A.
- R12: With OUT_REG=1, both outputs show the effect of an input one clock edge later, and an active-low reset clears both outputs to 0x00.
- R13: Unassigned opcodes 14 and 15 return A and an unchanged status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset of the output stage |
| op_i | input | 4 | Operation code |
| a_i | input | DATA_W | Accumulator or register operand |
| b_i | input | DATA_W | Memory operand |
| status_i | input | 8 | Current status byte |
| flag_sel_i | input | 3 | Bit index for opcodes 12 and 13 |
| result_o | output | DATA_W | Result byte |
| status_o | output | 8 | Updated status byte |

## Verification
Directed corner cases come first:
- signed overflow in both directions and carry out at 0xFF+1 on add;
- a borrow chain with carry clear on subtract;
- equal and lesser operands on compare;
- wrap at 0x00 and 0xFF on increment and decrement;
- a set carry that must appear at the opposite end of a rotate.

These cases separate the carry, overflow and zero rules that random operands seldom reach. A long run of seeded random opcodes, operands and status bytes with the upper bits set follows. It shows whether each operation leaves the flags it does not own untouched, because the interrupt-disable, decimal and break bits are held high or low across mixed operations. Checks during reset and in the cycle before the clock edge show the reset value and the single-cycle latency.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int unsigned ST_W = 8;
   localparam int unsigned FL_C = 0;
   localparam int unsigned FL_Z = 1;
   localparam int unsigned FL_V = 6;
   localparam int unsigned FL_N = 7;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_CMP  = 4'd5,
      OP_INC  = 4'd6,
      OP_DEC  = 4'd7,
      OP_SHL  = 4'd8,
      OP_SHR  = 4'd9,
      OP_ROL  = 4'd10,
      OP_ROR  = 4'd11,
      OP_FSET = 4'd12,
      OP_FCLR = 4'd13
   } alu_op_e;

   // true for operations whose result byte drives zero and negative
   function automatic logic writes_nz(input logic [3:0] op);
      return (op <= 4'd4) || ((op >= 4'd6) && (op <= 4'd11));
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
   import alu8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   output logic [W-1:0] sum_o,
   output logic         c_o,
   output logic         v_o
);

   logic [W-1:0] addend;
   logic         cin;
   logic [W:0]   full;

   // one adder serves add, subtract, compare, increment and decrement
   always_comb begin
      case (alu_op_e'(op_i))
         OP_SUB:  begin addend = ~b_i;      cin = c_i;  end
         OP_CMP:  begin addend = ~b_i;      cin = 1'b1; end
         OP_INC:  begin addend = '0;        cin = 1'b1; end
         OP_DEC:  begin addend = '1;        cin = 1'b0; end
         default: begin addend = b_i;       cin = c_i;  end
      endcase
   end

   assign full  = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin};
   assign sum_o = full[W-1:0];
   assign c_o   = full[W];
   assign v_o   = (a_i[W-1] == addend[W-1]) && (full[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   output logic [W-1:0] res_o,
   output logic         c_o
);

   always_comb begin
      res_o = a_i;
      c_o   = c_i;
      case (alu_op_e'(op_i))
         OP_AND: res_o = a_i & b_i;
         OP_OR:  res_o = a_i | b_i;
         OP_XOR: res_o = a_i ^ b_i;
         OP_SHL: begin res_o = {a_i[W-2:0], 1'b0}; c_o = a_i[W-1]; end
         OP_SHR: begin res_o = {1'b0, a_i[W-1:1]}; c_o = a_i[0];   end
         OP_ROL: begin res_o = {a_i[W-2:0], c_i};  c_o = a_i[W-1]; end
         OP_ROR: begin res_o = {c_i, a_i[W-1:1]};  c_o = a_i[0];   end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_merge.sv
module alu8_merge
   import alu8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]      op_i,
   input  logic [W-1:0]    a_i,
   input  logic [ST_W-1:0] st_i,
   input  logic [2:0]      sel_i,
   input  logic [W-1:0]    sum_i,
   input  logic            sum_c_i,
   input  logic            sum_v_i,
   input  logic [W-1:0]    bit_i,
   input  logic            bit_c_i,
   output logic [W-1:0]    res_o,
   output logic [ST_W-1:0] st_o
);

   logic upd_nz;

   always_comb begin
      res_o  = a_i;
      st_o   = st_i;
      upd_nz = 1'b0;
      case (alu_op_e'(op_i))
         OP_ADD, OP_SUB: begin
            res_o      = sum_i;
            st_o[FL_C] = sum_c_i;
            st_o[FL_V] = sum_v_i;
            upd_nz     = 1'b1;
         end
         OP_CMP: begin
            st_o[FL_C] = sum_c_i;
            st_o[FL_Z] = (sum_i == '0);
            st_o[FL_N] = sum_i[W-1];
         end
         OP_INC, OP_DEC: begin
            res_o  = sum_i;
            upd_nz = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_o  = bit_i;
            upd_nz = 1'b1;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            res_o      = bit_i;
            st_o[FL_C] = bit_c_i;
            upd_nz     = 1'b1;
         end
         OP_FSET: st_o[sel_i] = 1'b1;
         OP_FCLR: st_o[sel_i] = 1'b0;
         default: ;
      endcase
      if (upd_nz) begin
         st_o[FL_Z] = (res_o == '0);
         st_o[FL_N] = res_o[W-1];
      end
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OUT_REG = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [ST_W-1:0]   status_i,
   input  logic [2:0]        flag_sel_i,
   output logic [DATA_W-1:0] result_o,
   output logic [ST_W-1:0]   status_o
);

   if (DATA_W < 2) begin : g_bad_w
      $error("alu8_core: DATA_W must be at least 2");
   end
   if (OUT_REG > 1) begin : g_bad_r
      $error("alu8_core: OUT_REG must be 0 or 1");
   end

   logic [DATA_W-1:0] sum, bits, nx_res;
   logic              sum_c, sum_v, bit_c;
   logic [ST_W-1:0]   nx_st;

   alu8_adder #(.W(DATA_W)) u_add (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .c_i  (status_i[FL_C]),
      .sum_o(sum),
      .c_o  (sum_c),
      .v_o  (sum_v)
   );

   alu8_bitops #(.W(DATA_W)) u_bit (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .c_i  (status_i[FL_C]),
      .res_o(bits),
      .c_o  (bit_c)
   );

   alu8_merge #(.W(DATA_W)) u_mrg (
      .op_i   (op_i),
      .a_i    (a_i),
      .st_i   (status_i),
      .sel_i  (flag_sel_i),
      .sum_i  (sum),
      .sum_c_i(sum_c),
      .sum_v_i(sum_v),
      .bit_i  (bits),
      .bit_c_i(bit_c),
      .res_o  (nx_res),
      .st_o   (nx_st)
   );

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            result_o <= '0;
            status_o <= '0;
         end else begin
            result_o <= nx_res;
            status_o <= nx_st;
         end
      end
   end else begin : g_comb
      assign result_o = nx_res;
      assign status_o = nx_st;
   end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OUT_REG = 1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [ST_W-1:0]   status_i,
   input logic [2:0]        flag_sel_i,
   input logic [DATA_W-1:0] result_o,
   input logic [ST_W-1:0]   status_o
);

   logic [3:0]        s_op;
   logic [DATA_W-1:0] s_a, s_b;
   logic [ST_W-1:0]   s_st;
   logic [2:0]        s_sel;
   logic              s_vld;

   // inputs aligned with the outputs they produced
   if (OUT_REG == 1) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            s_op <= '0; s_a <= '0; s_b <= '0; s_st <= '0; s_sel <= '0;
         end else begin
            s_op <= op_i; s_a <= a_i; s_b <= b_i; s_st <= status_i; s_sel <= flag_sel_i;
         end
      end
   end else begin : g_now
      always_comb begin
         s_op = op_i; s_a = a_i; s_b = b_i; s_st = status_i; s_sel = flag_sel_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_vld <= 1'b0;
      else         s_vld <= 1'b1;
   end

   // R1
   sys_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && s_op != OP_FSET && s_op != OP_FCLR) |-> status_o[5:2] == s_st[5:2]);

   // R2
   zn_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && writes_nz(s_op)) |->
         (status_o[FL_Z] == (result_o == '0)) && (status_o[FL_N] == result_o[DATA_W-1]));

   // R6
   cmp_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && s_op == OP_CMP) |->
         (result_o == s_a) && (status_o[FL_C] == (s_a >= s_b)) && (status_o[FL_V] == s_st[FL_V]));

   // R7
   incdec_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && (s_op == OP_INC || s_op == OP_DEC)) |->
         (status_o[FL_C] == s_st[FL_C]) && (status_o[FL_V] == s_st[FL_V]));

   // R8
   logic_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && (s_op == OP_AND || s_op == OP_OR || s_op == OP_XOR)) |->
         (status_o[FL_C] == s_st[FL_C]) && (status_o[FL_V] == s_st[FL_V]));

   // R11
   flag_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && (s_op == OP_FSET || s_op == OP_FCLR)) |->
         (result_o == s_a) && (status_o[s_sel] == (s_op == OP_FSET)));

   // R13
   undef_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && s_op >= 4'd14) |-> (result_o == s_a) && (status_o == s_st));

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

   localparam time CLK_P = 8ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] a = '0, b = '0, st = '0;
   logic [2:0] sel = '0;
   logic [7:0] res_o, st_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   alu8_core #(.DATA_W(8), .OUT_REG(1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .status_i(st), .flag_sel_i(sel), .result_o(res_o), .status_o(st_o)
   );

   function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] x,
                                         input logic [7:0] m, input logic [7:0] s0,
                                         input logic [2:0] k);
      logic [7:0] r, s, d;
      int t;
      bit nz;
      r = x; s = s0; nz = 0;
      case (o)
         4'd0: begin
            t = int'(x) + int'(m) + int'(s0[0]);
            r = t[7:0]; s[0] = (t > 255);
            s[6] = (x[7] == m[7]) && (r[7] != x[7]); nz = 1;
         end
         4'd1: begin
            t = int'(x) - int'(m) - (s0[0] ? 0 : 1);
            r = t[7:0]; s[0] = (t >= 0);
            s[6] = (x[7] != m[7]) && (r[7] != x[7]); nz = 1;
         end
         4'd2: begin r = x & m; nz = 1; end
         4'd3: begin r = x | m; nz = 1; end
         4'd4: begin r = x ^ m; nz = 1; end
         4'd5: begin d = x - m; s[0] = (x >= m); s[1] = (d == 0); s[7] = d[7]; end
         4'd6: begin r = x + 8'd1; nz = 1; end
         4'd7: begin r = x - 8'd1; nz = 1; end
         4'd8: begin r = x << 1; s[0] = x[7]; nz = 1; end
         4'd9: begin r = x >> 1; s[0] = x[0]; nz = 1; end
         4'd10: begin r = (x << 1) | {7'd0, s0[0]}; s[0] = x[7]; nz = 1; end
         4'd11: begin r = (x >> 1) | {s0[0], 7'd0}; s[0] = x[0]; nz = 1; end
         4'd12: s[k] = 1'b1;
         4'd13: s[k] = 1'b0;
         default: ;
      endcase
      if (nz) begin s[1] = (r == 0); s[7] = r[7]; end
      return {r, s};
   endfunction

   task automatic cmp(input string tag, input logic [7:0] er, input logic [7:0] es);
      total++;
      if (res_o !== er || st_o !== es) begin
         bad++;
         $display("FAIL %s op=%0d a=%h b=%h st=%h: actual res=%h st=%h expected res=%h st=%h",
                  tag, op, a, b, st, res_o, st_o, er, es);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the result registers
   task automatic run(input string tag, input logic [3:0] o, input logic [7:0] x,
                      input logic [7:0] m, input logic [7:0] s0, input logic [2:0] k);
      logic [15:0] e;
      op = o; a = x; b = m; st = s0; sel = k;
      e = model(o, x, m, s0, k);
      @(posedge clk);
      @(negedge clk);
      cmp(tag, e[15:8], e[7:0]);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R12: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] prev;
      void'($urandom(32'd20240611));
      op = 4'd0; a = 8'h5A; b = 8'h33; st = 8'hFF;
      repeat (3) @(negedge clk);
      // R12: reset clears both outputs
      cmp("R12 reset", 8'h00, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 / R4 add corners
      run("R3 carry out", 4'd0, 8'hFF, 8'h01, 8'h00, 3'd0);
      run("R4 add overflow", 4'd0, 8'h50, 8'h50, 8'h00, 3'd0);
      run("R3 add carry in", 4'd0, 8'h10, 8'h20, 8'h01, 3'd0);
      cmp("R3 literal", 8'h31, 8'h00);
      // R5 / R4 subtract corners
      run("R5 borrow", 4'd1, 8'h50, 8'hF0, 8'h01, 3'd0);
      run("R4 sub overflow", 4'd1, 8'h80, 8'h01, 8'h01, 3'd0);
      run("R5 carry clear", 4'd1, 8'h05, 8'h05, 8'h00, 3'd0);
      cmp("R5 literal", 8'hFF, 8'h80);
      // R6 compare
      run("R6 equal", 4'd5, 8'h42, 8'h42, 8'h40, 3'd0);
      run("R6 less", 4'd5, 8'h10, 8'h20, 8'h41, 3'd0);
      // R7 wrap
      run("R7 inc wrap", 4'd6, 8'hFF, 8'h00, 8'h41, 3'd0);
      run("R7 dec wrap", 4'd7, 8'h00, 8'h00, 8'h40, 3'd0);
      // R8 logic
      run("R8 and", 4'd2, 8'hF0, 8'h0F, 8'h41, 3'd0);
      run("R8 or", 4'd3, 8'h80, 8'h01, 8'h00, 3'd0);
      run("R8 xor", 4'd4, 8'hAA, 8'hAA, 8'h41, 3'd0);
      // R9 shifts
      run("R9 shl", 4'd8, 8'h81, 8'h00, 8'h00, 3'd0);
      run("R9 shr", 4'd9, 8'h01, 8'h00, 8'h40, 3'd0);
      // R10 rotates
      run("R10 rol", 4'd10, 8'h80, 8'h00, 8'h01, 3'd0);
      cmp("R10 rol literal", 8'h01, 8'h01);
      run("R10 ror", 4'd11, 8'h01, 8'h00, 8'h01, 3'd0);
      cmp("R10 ror literal", 8'h80, 8'h81);
      // R11 flag set / clear
      run("R11 set", 4'd12, 8'h3C, 8'h00, 8'h00, 3'd3);
      run("R11 clear", 4'd13, 8'h3C, 8'h00, 8'hFF, 3'd0);
      // R13 unassigned codes
      run("R13 op14", 4'd14, 8'h77, 8'h11, 8'hA5, 3'd2);
      run("R13 op15", 4'd15, 8'h00, 8'hFF, 8'h5A, 3'd5);
      // R1 system bits kept under mixed operations
      run("R1 keep high", 4'd0, 8'h01, 8'h01, 8'h3C, 3'd0);
      run("R1 keep low", 4'd8, 8'hC3, 8'h00, 8'hC3, 3'd0);

      // R12: output must not move before the clock edge
      prev = model(op, a, b, st, sel);
      op = 4'd4; a = 8'h0F; b = 8'hF0; st = 8'h00;
      #1;
      cmp("R12 latency", prev[15:8], prev[7:0]);
      @(posedge clk); @(negedge clk);
      cmp("R12 after edge", 8'hFF, 8'h80);

      // R2 and all operations: seeded random mix
      for (int i = 0; i < 3000; i++) begin
         run("R2 random", 4'($urandom_range(15)), 8'($urandom), 8'($urandom),
             8'($urandom), 3'($urandom_range(7)));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule